// File: doc/BRIEF.md
# I2C SCL Period Generator

This block produces the serial clock waveform of an I2C master. It alternates between a low phase, in which it pulls SCL down, and a released phase, in which it lets the line float high. Each phase length comes from a programmable count in controller clock ticks. Two count pairs are held, one for standard-speed and one for fast-speed operation, and a control bit picks which pair is loaded at the start of each phase.

After SCL is released, the high count does not begin until the line is actually observed high through an input synchronizer. A target device that holds SCL low therefore stretches the released phase by the time it holds it. A neighbouring bit engine gets the current phase code and single-cycle pulses marking each falling and each counted rising edge. With these it can change data during the low phase. Start/stop generation, data shifting and arbitration live elsewhere.

Top module: `scl_period_gen`

## Requirements
- R1: While reset is asserted and after its release, SCL is released (`scl_drive_low`=0), `scl_phase` is 2'b00 and both pulses are 0.
- R2: Writes decode as follows. Offset 0x14 is the standard high count and 0x18 the standard low count. Offset 0x1C is the fast high count and 0x20 the fast low count. At offset 0x00, bit 1 selects fast when set. At offset 0x6C, bit 0 runs the generator when set.
- R3: A low phase holds `scl_drive_low`=1 for max(LOW,1)+1 cycles. It starts one cycle after the write that sets the run bit, and otherwise at the end of a high phase.
- R4: Without stretching, SCL stays released for HIGH+8 cycles between two low phases.
- R5: If SCL is held low externally for S cycles after release, the released phase lasts S+HIGH+8 cycles. The high count starts only after SCL is seen high through a 2-stage synchronizer, and `scl_rise_pulse` falls in released cycle S+3, counting from 0.
- R6: The count pair used for each phase is the fast pair when the speed bit is 1 and the standard pair when it is 0.
- R7: Count writes are ignored while the run bit is 1 and accepted while it is 0.
- R8: Clearing the run bit releases SCL and returns `scl_phase` to 2'b00 by the second cycle after the write, with no pulses while stopped.
- R9: `scl_fall_pulse` is 1 for exactly the first cycle of each low phase, and `scl_rise_pulse` for exactly the first counted high cycle. The two are never 1 together.
- R10: `scl_phase` reads 2'b01 while driving low, 2'b10 while released and waiting to see SCL high, and 2'b11 while counting the high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| scl_in | input | 1 | Sensed level of the SCL line |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| scl_fall_pulse | output | 1 | First cycle of each low phase |
| scl_rise_pulse | output | 1 | First cycle of each counted high phase |
| scl_phase | output | 2 | Current phase code |

## Verification
A register write is captured on the edge where `reg_we` is seen. The generator reacts on the following edge, so the first low cycle and the return to idle both appear two edges after the strobe. The sensed SCL level passes through two synchronizer flops plus the phase register, which places the rise pulse three cycles after the line really goes high. The bench counts whole cycles of each phase at falling clock edges and compares them with max(LOW,1)+1 and S+HIGH+8. It checks the phase code and pulses on the first sampled cycle of each phase.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_LOW  = 2'b01,
    PH_WAIT = 2'b10,
    PH_HIGH = 2'b11
  } phase_e;

  localparam logic [7:0] OFS_CTRL    = 8'h00;
  localparam logic [7:0] OFS_STD_HI  = 8'h14;
  localparam logic [7:0] OFS_STD_LO  = 8'h18;
  localparam logic [7:0] OFS_FST_HI  = 8'h1C;
  localparam logic [7:0] OFS_FST_LO  = 8'h20;
  localparam logic [7:0] OFS_RUN     = 8'h6C;
  localparam int         CTRL_FAST_BIT = 1;
  localparam int         RUN_BIT       = 0;
endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs
  import scl_gen_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              run_en,
  output logic              fast_sel,
  output logic [CNT_W-1:0]  hi_sel,
  output logic [CNT_W-1:0]  lo_sel
);
  localparam int NUM_CNT = 4;
  localparam logic [ADDR_W-1:0] CNT_OFS [NUM_CNT] = '{
    ADDR_W'(OFS_STD_HI), ADDR_W'(OFS_STD_LO),
    ADDR_W'(OFS_FST_HI), ADDR_W'(OFS_FST_LO)
  };

  logic [CNT_W-1:0] cnt_q [NUM_CNT];
  logic             run_q, fast_q;
  logic             run_d, fast_d;
  logic             ctrl_hit, run_hit;

  assign ctrl_hit = we && (addr == ADDR_W'(OFS_CTRL));
  assign run_hit  = we && (addr == ADDR_W'(OFS_RUN));

  always_comb begin
    run_d  = run_q;
    fast_d = fast_q;
    if (run_hit)  run_d  = wdata[RUN_BIT];
    if (ctrl_hit) fast_d = wdata[CTRL_FAST_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      fast_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      fast_q <= fast_d;
    end
  end

  for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
    logic cnt_ce;
    assign cnt_ce = we && !run_q && (addr == CNT_OFS[gi]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[gi] <= '0;
      end else if (cnt_ce) begin
        cnt_q[gi] <= wdata[CNT_W-1:0];
      end
    end
  end

  assign run_en   = run_q;
  assign fast_sel = fast_q;
  assign hi_sel   = fast_q ? cnt_q[2] : cnt_q[0];
  assign lo_sel   = fast_q ? cnt_q[3] : cnt_q[1];
endmodule

// File: rtl/scl_in_sync.sv
module scl_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  for (genvar gs = 0; gs < STAGES; gs++) begin : g_stage
    logic stage_d;
    if (gs == 0) begin : g_first
      assign stage_d = din;
    end else begin : g_next
      assign stage_d = chain_q[gs-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[gs] <= 1'b1;
      else        chain_q[gs] <= stage_d;
    end
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_gen_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int HIGH_OVH    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [CNT_W-1:0] hi_cnt,
  input  logic [CNT_W-1:0] lo_cnt,
  input  logic             scl_high_seen,
  output logic             drive_low,
  output logic             fall_pulse,
  output logic             rise_pulse,
  output logic [1:0]       phase
);
  localparam int CW      = CNT_W + 1;
  localparam int HI_ADJ  = HIGH_OVH - SYNC_STAGES - 2;
  localparam int MIN_LO  = (SYNC_STAGES > 1) ? SYNC_STAGES - 1 : 0;

  phase_e         ph_q, ph_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           drv_q, drv_d;
  logic           fall_q, fall_d;
  logic           rise_q, rise_d;
  logic           step_ce;
  logic [CW-1:0]  lo_load, hi_load;

  assign lo_load = (lo_cnt < CNT_W'(MIN_LO)) ? CW'(MIN_LO) : {1'b0, lo_cnt};
  assign hi_load = {1'b0, hi_cnt} + CW'(HI_ADJ);
  assign step_ce = run_en || (ph_q != PH_IDLE) || fall_q || rise_q;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    drv_d  = drv_q;
    fall_d = 1'b0;
    rise_d = 1'b0;
    if (!run_en) begin
      ph_d  = PH_IDLE;
      cnt_d = '0;
      drv_d = 1'b0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          ph_d   = PH_LOW;
          cnt_d  = lo_load;
          drv_d  = 1'b1;
          fall_d = 1'b1;
        end
        PH_LOW: begin
          if (cnt_q == '0) begin
            ph_d  = PH_WAIT;
            drv_d = 1'b0;
          end else begin
            cnt_d = cnt_q - CW'(1);
          end
        end
        PH_WAIT: begin
          if (scl_high_seen) begin
            ph_d   = PH_HIGH;
            cnt_d  = hi_load;
            rise_d = 1'b1;
          end
        end
        PH_HIGH: begin
          if (cnt_q == '0) begin
            ph_d   = PH_LOW;
            cnt_d  = lo_load;
            drv_d  = 1'b1;
            fall_d = 1'b1;
          end else begin
            cnt_d = cnt_q - CW'(1);
          end
        end
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      drv_q  <= 1'b0;
      fall_q <= 1'b0;
      rise_q <= 1'b0;
    end else if (step_ce) begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      drv_q  <= drv_d;
      fall_q <= fall_d;
      rise_q <= rise_d;
    end
  end

  assign drive_low  = drv_q;
  assign fall_pulse = fall_q;
  assign rise_pulse = rise_q;
  assign phase      = ph_q;
endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen #(
  parameter int CNT_W       = 16,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int HIGH_OVH    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              scl_in,
  output logic              scl_drive_low,
  output logic              scl_fall_pulse,
  output logic              scl_rise_pulse,
  output logic [1:0]        scl_phase
);
  logic             run_en;
  logic             fast_sel;
  logic [CNT_W-1:0] hi_sel, lo_sel;
  logic             scl_sync;

  scl_cfg_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .run_en   (run_en),
    .fast_sel (fast_sel),
    .hi_sel   (hi_sel),
    .lo_sel   (lo_sel)
  );

  scl_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (scl_in),
    .dout  (scl_sync)
  );

  scl_phase_fsm #(.CNT_W(CNT_W), .HIGH_OVH(HIGH_OVH), .SYNC_STAGES(SYNC_STAGES)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .run_en        (run_en),
    .hi_cnt        (hi_sel),
    .lo_cnt        (lo_sel),
    .scl_high_seen (scl_sync),
    .drive_low     (scl_drive_low),
    .fall_pulse    (scl_fall_pulse),
    .rise_pulse    (scl_rise_pulse),
    .phase         (scl_phase)
  );
endmodule

// File: rtl/scl_period_gen_chk.sv
module scl_period_gen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             fast_sel,
  input logic [CNT_W-1:0] hi_sel,
  input logic [CNT_W-1:0] lo_sel,
  input logic             drive_low,
  input logic             fall_pulse,
  input logic             rise_pulse,
  input logic [1:0]       phase
);
  assert_release_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !drive_low);

  assert_no_pulse_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !(fall_pulse || rise_pulse) || !$past(run_en, 1) && !run_en && 1'b0 || !drive_low && !fall_pulse);

  assert_fall_marks_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_low) |-> fall_pulse);

  assert_fall_only_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fall_pulse |-> drive_low);

  assert_rise_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse |-> !drive_low && (phase == 2'b11));

  assert_pulses_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fall_pulse, rise_pulse}));

  assert_phase_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b01) == drive_low);

  assert_cnt_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run_en) && $stable(fast_sel) |-> $stable(hi_sel) && $stable(lo_sel));
endmodule

bind scl_period_gen scl_period_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_en     (run_en),
  .fast_sel   (fast_sel),
  .hi_sel     (hi_sel),
  .lo_sel     (lo_sel),
  .drive_low  (scl_drive_low),
  .fall_pulse (scl_fall_pulse),
  .rise_pulse (scl_rise_pulse),
  .phase      (scl_phase)
);

// File: tb/scl_period_gen_bench.sv
`timescale 1ns/1ps
module scl_period_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic        scl_in;
  logic        scl_drive_low, scl_fall_pulse, scl_rise_pulse;
  logic [1:0]  scl_phase;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int stretch_cfg = 0;
  int stretch_left = 0;

  always #5 clk = ~clk;

  scl_period_gen u_scl_period_gen (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .scl_in(scl_in), .scl_drive_low(scl_drive_low),
    .scl_fall_pulse(scl_fall_pulse), .scl_rise_pulse(scl_rise_pulse),
    .scl_phase(scl_phase)
  );

  // open-drain line model with a target that holds SCL low after release
  always @(posedge clk) begin
    if (scl_drive_low) stretch_left <= stretch_cfg;
    else if (stretch_left > 0) stretch_left <= stretch_left - 1;
  end
  assign scl_in = !(scl_drive_low || (stretch_left != 0));

  // {fast, high, low, stretch}
  localparam logic [63:0] VECS [5] = '{
    {16'd0, 16'd3,  16'd2, 16'd0},
    {16'd1, 16'd5,  16'd4, 16'd0},
    {16'd0, 16'd0,  16'd0, 16'd0},
    {16'd1, 16'd2,  16'd6, 16'd3},
    {16'd0, 16'd10, 16'd1, 16'd5}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // skips any low phase in progress, then measures one low and one released phase
  task automatic measure(input int exp_low, input int exp_rel, input int exp_rise,
                         input string tag_lo, input string tag_hi);
    int n, m, rise_at, rise_cnt;
    n = 0; m = 0; rise_at = -1; rise_cnt = 0;
    while (scl_drive_low && n < 200000) begin @(negedge clk); n++; end
    n = 0;
    while (!scl_drive_low && n < 200000) begin @(negedge clk); n++; end
    check(scl_fall_pulse === 1'b1, "R9 fall pulse at low start", scl_fall_pulse, 1);
    check(scl_phase === 2'b01, "R10 phase code low", scl_phase, 1);
    n = 0;
    while (scl_drive_low && n < 200000) begin
      if (n > 0 && scl_fall_pulse) rise_cnt = rise_cnt + 100;
      n++; @(negedge clk);
    end
    check(n == exp_low, tag_lo, n, exp_low);
    check(scl_phase === 2'b10 || exp_rise == 0, "R10 phase code wait", scl_phase, 2);
    while (!scl_drive_low && m < 200000) begin
      if (scl_rise_pulse) begin rise_at = m; rise_cnt++; end
      if (m == exp_rise) check(scl_phase === 2'b11, "R10 phase code high", scl_phase, 3);
      m++; @(negedge clk);
    end
    check(m == exp_rel, tag_hi, m, exp_rel);
    check(rise_at == exp_rise && rise_cnt == 1, "R9 R5 rise pulse position", rise_at, exp_rise);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(scl_drive_low === 1'b0, "R1 released in reset", scl_drive_low, 0);
    check(scl_phase === 2'b00, "R1 phase idle in reset", scl_phase, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!scl_fall_pulse && !scl_rise_pulse && !scl_drive_low, "R1 quiet after reset",
          scl_drive_low, 0);

    for (int i = 0; i < 5; i++) begin
      logic        fast;
      int          hi, lo, st, exp_lo, exp_rel;
      string       tlo, thi;
      fast = VECS[i][48];
      hi = int'(VECS[i][47:32]);
      lo = int'(VECS[i][31:16]);
      st = int'(VECS[i][15:0]);
      wr(8'h6C, 16'h0000);
      wr(8'h14, fast ? 16'(hi + 7) : 16'(hi));
      wr(8'h18, fast ? 16'(lo + 5) : 16'(lo));
      wr(8'h1C, fast ? 16'(hi) : 16'(hi + 7));
      wr(8'h20, fast ? 16'(lo) : 16'(lo + 5));
      wr(8'h00, {14'd0, fast, 1'b0});
      stretch_cfg = st;
      wr(8'h6C, 16'h0001);
      exp_lo  = ((lo < 1) ? 1 : lo) + 1;
      exp_rel = st + hi + 8;
      tlo = fast ? "R3 R6 R2 low length (fast pair)" : "R3 R2 low length (std pair)";
      thi = (st > 0) ? "R5 R6 stretched released length" : "R4 R2 released length";
      measure(exp_lo, exp_rel, st + 3, tlo, thi);
      measure(exp_lo, exp_rel, st + 3, tlo, thi);
    end

    // R7 writes ignored while running, accepted when stopped
    wr(8'h6C, 16'h0000);
    stretch_cfg = 0;
    wr(8'h00, 16'h0000);
    wr(8'h14, 16'd4);
    wr(8'h18, 16'd3);
    wr(8'h6C, 16'h0001);
    measure(4, 12, 3, "R3 low length before write", "R4 released length");
    wr(8'h18, 16'd20);
    wr(8'h14, 16'd30);
    measure(4, 12, 3, "R7 low count unchanged while running", "R7 high count unchanged while running");

    // R8 stop releases SCL by the second cycle after the write
    while (!scl_drive_low) @(negedge clk);
    wr(8'h6C, 16'h0000);
    @(negedge clk);
    check(scl_drive_low === 1'b0, "R8 released after stop", scl_drive_low, 0);
    check(scl_phase === 2'b00, "R8 phase idle after stop", scl_phase, 0);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (scl_drive_low || scl_fall_pulse || scl_rise_pulse || scl_phase != 2'b00)
        check(1'b0, "R8 quiet while stopped", scl_drive_low, 0);
    end
    checks++;

    wr(8'h18, 16'd6);
    wr(8'h6C, 16'h0001);
    measure(7, 12, 3, "R7 low count accepted while stopped", "R4 released length");

    wr(8'h6C, 16'h0000);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule